// File: doc/BRIEF.md
# Unaligned Load Data Aligner

This block sits on the load path between the memory read bus and the register file. The bus always returns an aligned 32-bit word. From that word, the low two address bits, the access size and a signed flag, the block forms the value written to the destination register.

Misaligned accesses never fault and are never forced to an aligned result. A misaligned word load comes back rotated. A halfword load from an odd address also comes back rotated. A signed halfword load from an odd address sign-extends a single byte.

Requests enter and results leave through valid/ready handshakes. A parameter chooses between two variants:

- **Registered variant (default):** one output register holds the result. The upstream side is ready when that register is empty, or when its contents are being taken in the same cycle. A result that is offered but not taken stays on the outputs, unchanged, until the consumer raises ready.
- **Combinational variant:** the result follows the request in the same cycle, and back-pressure passes straight through.

Top module: `load_aligner`

## Requirements
- R1: With size code 2'b10 (word) the result is the input word rotated right by 8 × addr[1:0] bits. For example, data C3A57E81 at addr 1 gives 81C3A57E.
- R2: For size code 2'b10 the signed flag has no effect. Size code 2'b11 behaves exactly like 2'b10.
- R3: With size code 2'b01 (halfword) and the signed flag clear, the halfword lane is selected by addr[1] (0 selects bits 15:0, 1 selects bits 31:16).
  - At an even address the lane is zero-extended.
  - At an odd address the result places the lane's low byte in bits 31:24 and its high byte in bits 7:0, with bits 23:8 zero.
- R4: For a signed halfword at an even address, the selected lane is sign-extended from its bit 15.
- R5: For a signed halfword at an odd address, the result is the high byte of the selected lane, sign-extended from its bit 7.
- R6: With size code 2'b00 (byte), byte lane addr[1:0] is selected (lane 0 is bits 7:0). The byte is zero-extended when the signed flag is clear and sign-extended when it is set.
- R7: In the registered variant, a request accepted at a clock edge shows on out_data with out_valid high right after that edge. With no new request, out_valid drops after the result is taken.
- R8: In the registered variant, while out_valid is high and out_ready is low, out_data and out_valid hold and in_ready is low.
- R9: In the combinational variant, out_valid and out_data follow the request in the same cycle, and in_ready equals out_ready.
- R10: During reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Load request present |
| in_ready | output | 1 | Block can take a request |
| in_data | input | DW (32) | Aligned word read from the bus |
| in_addr | input | 2 | Low address bits of the load |
| in_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| in_signed | input | 1 | Sign-extend byte and halfword results |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DW (32) | Value for the destination register |

## Verification
In the registered variant a result is due one clock edge after the request is accepted. The bench drives each request on a falling edge and samples the result on the next falling edge, half a period after the capturing rising edge. In the combinational variant the result is due in the same cycle, so a second instance is checked shortly after the inputs change, before any rising edge. The back-pressure scenario holds out_ready low across two edges and samples between them to confirm the held result and the low in_ready. It then releases out_ready and samples one edge later for the queued request.

// File: rtl/load_align_pkg.sv
package load_align_pkg;
  typedef enum logic [1:0] {
    LD_BYTE = 2'b00,
    LD_HALF = 2'b01,
    LD_WORD = 2'b10,
    LD_WALT = 2'b11
  } ld_size_e;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned HALF_W = 16;
endpackage

// File: rtl/la_rotor.sv
module la_rotor #(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int AW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] sel,
  output logic [DW-1:0] dout
);
  // lane g of the output takes input lane (g + sel) mod NL
  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [AW-1:0] src;
    assign src = sel + AW'(g);
    assign dout[g*8 +: 8] = din[src*8 +: 8];
  end

  // rotating the result back to the left must restore the input (R1)
  logic [2*DW-1:0] back;
  assign back = {dout, dout} >> (DW - 8 * int'(sel));

  a_r1_rotate_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    back[DW-1:0] == din);
endmodule

// File: rtl/la_lane_pick.sv
module la_lane_pick #(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int AW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] sel,
  output logic [15:0]   half_lane,
  output logic [7:0]    byte_lane
);
  logic [AW-2:0] hsel;
  assign hsel      = sel[AW-1:1];
  assign half_lane = din[hsel*16 +: 16];
  assign byte_lane = din[sel*8 +: 8];

  // the picked byte is always one of the halves of the picked halfword (R6)
  a_r6_byte_in_half: assert property (@(posedge clk) disable iff (!rst_n)
    byte_lane == (sel[0] ? half_lane[15:8] : half_lane[7:0]));
endmodule

// File: rtl/la_extend.sv
module la_extend
  import load_align_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ld_size_e      size,
  input  logic          sgn,
  input  logic          odd,
  input  logic [DW-1:0] word_rot,
  input  logic [15:0]   half_lane,
  input  logic [7:0]    byte_lane,
  output logic [DW-1:0] res
);
  always_comb begin
    unique case (size)
      LD_BYTE: res = sgn ? {{(DW-8){byte_lane[7]}}, byte_lane}
                         : {{(DW-8){1'b0}}, byte_lane};
      LD_HALF: begin
        if (odd)
          res = sgn ? {{(DW-8){half_lane[15]}}, half_lane[15:8]}
                    : {half_lane[7:0], {(DW-16){1'b0}}, half_lane[15:8]};
        else
          res = sgn ? {{(DW-16){half_lane[15]}}, half_lane}
                    : {{(DW-16){1'b0}}, half_lane};
      end
      default: res = word_rot;
    endcase
  end

  logic is_half;
  assign is_half = (size == LD_HALF);

  a_r3_odd_middle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (is_half && !sgn && odd) |-> (res[DW-9:8] == '0));
  a_r4_even_half_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (is_half && sgn && !odd) |->
      ($countones(res[DW-1:15]) == 0 || $countones(res[DW-1:15]) == DW-15));
  a_r5_odd_half_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (is_half && sgn && odd) |->
      ($countones(res[DW-1:7]) == 0 || $countones(res[DW-1:7]) == DW-7));
  a_r6_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (size == LD_BYTE && !sgn) |-> (res[DW-1:8] == '0));
endmodule

// File: rtl/la_out_stage.sv
module la_out_stage #(
  parameter int DW      = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  if (OUT_REG) begin : g_reg
    logic          vld_q;
    logic [DW-1:0] dat_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) dat_q <= in_data;
      end
    end

    a_r7_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r8_stall_upstream: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/load_aligner.sv
module load_aligner
  import load_align_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int AW     = $clog2(DW / 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_size,
  input  logic          in_signed,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  ld_size_e      size;
  logic [DW-1:0] word_rot;
  logic [15:0]   half_lane;
  logic [7:0]    byte_lane;
  logic [DW-1:0] result;

  assign size = ld_size_e'(in_size);

  la_rotor #(.DW(DW)) u_rot (
    .clk(clk), .rst_n(rst_n), .din(in_data), .sel(in_addr), .dout(word_rot)
  );

  la_lane_pick #(.DW(DW)) u_pick (
    .clk(clk), .rst_n(rst_n), .din(in_data), .sel(in_addr),
    .half_lane(half_lane), .byte_lane(byte_lane)
  );

  la_extend #(.DW(DW)) u_ext (
    .clk(clk), .rst_n(rst_n), .size(size), .sgn(in_signed), .odd(in_addr[0]),
    .word_rot(word_rot), .half_lane(half_lane), .byte_lane(byte_lane),
    .res(result)
  );

  la_out_stage #(.DW(DW), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(result),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // word results are unaffected by the signed flag (R2)
  a_r2_word_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
    (size inside {LD_WORD, LD_WALT}) |-> (result == word_rot));
endmodule

// File: tb/load_aligner_test.sv
`timescale 1ns/1ps
module load_aligner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [1:0]  in_addr = '0;
  logic [1:0]  in_size = '0;
  logic        in_signed = 1'b0;
  logic        rdy = 1'b1;
  logic        o_valid, i_ready;
  logic [31:0] o_data;
  logic        c_valid, c_ready;
  logic [31:0] c_data;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  load_aligner uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(i_ready),
    .in_data(in_data), .in_addr(in_addr), .in_size(in_size),
    .in_signed(in_signed), .out_valid(o_valid), .out_ready(rdy),
    .out_data(o_data)
  );

  load_aligner #(.OUT_REG(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_ready),
    .in_data(in_data), .in_addr(in_addr), .in_size(in_size),
    .in_signed(in_signed), .out_valid(c_valid), .out_ready(1'b1),
    .out_data(c_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  localparam logic [31:0] D = 32'hC3A5_7E81;

  // one request through both variants; exp computed by hand from the requirements
  task automatic send(string req, logic [31:0] d, logic [1:0] a, logic [1:0] s,
                      logic sg, logic [31:0] exp);
    @(negedge clk);
    in_data = d; in_addr = a; in_size = s; in_signed = sg; in_valid = 1'b1;
    #1;
    check({req, " R9 comb data"}, c_data, exp);
    check({req, " R9 comb valid"}, {31'd0, c_valid}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R7 valid"}, {31'd0, o_valid}, 32'd1);
    check(req, o_data, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 out_valid in reset", {31'd0, o_valid}, 32'd0);
    check("R10 in_ready in reset", {31'd0, i_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_word;
    send("R1 word a0", D, 2'd0, 2'b10, 1'b0, 32'hC3A57E81);
    send("R1 word a1", D, 2'd1, 2'b10, 1'b0, 32'h81C3A57E);
    send("R1 word a2", D, 2'd2, 2'b10, 1'b0, 32'h7E81C3A5);
    send("R1 word a3", D, 2'd3, 2'b10, 1'b0, 32'hA57E81C3);
    send("R2 word signed a1", D, 2'd1, 2'b10, 1'b1, 32'h81C3A57E);
    send("R2 size 11 a2", D, 2'd2, 2'b11, 1'b1, 32'h7E81C3A5);
  endtask

  task automatic t_half_unsigned;
    send("R3 half a0", D, 2'd0, 2'b01, 1'b0, 32'h00007E81);
    send("R3 half a2", D, 2'd2, 2'b01, 1'b0, 32'h0000C3A5);
    send("R3 half odd a1", D, 2'd1, 2'b01, 1'b0, 32'h8100007E);
    send("R3 half odd a3", D, 2'd3, 2'b01, 1'b0, 32'hA50000C3);
  endtask

  task automatic t_half_signed;
    send("R4 shalf a0", D, 2'd0, 2'b01, 1'b1, 32'h00007E81);
    send("R4 shalf a2", D, 2'd2, 2'b01, 1'b1, 32'hFFFFC3A5);
    send("R5 shalf odd a1", D, 2'd1, 2'b01, 1'b1, 32'h0000007E);
    send("R5 shalf odd a3", D, 2'd3, 2'b01, 1'b1, 32'hFFFFFFC3);
  endtask

  task automatic t_byte;
    send("R6 byte a0", D, 2'd0, 2'b00, 1'b0, 32'h00000081);
    send("R6 byte a1", D, 2'd1, 2'b00, 1'b0, 32'h0000007E);
    send("R6 byte a2", D, 2'd2, 2'b00, 1'b0, 32'h000000A5);
    send("R6 byte a3", D, 2'd3, 2'b00, 1'b0, 32'h000000C3);
    send("R6 sbyte a0", D, 2'd0, 2'b00, 1'b1, 32'hFFFFFF81);
    send("R6 sbyte a1", D, 2'd1, 2'b00, 1'b1, 32'h0000007E);
    send("R6 sbyte a2", D, 2'd2, 2'b00, 1'b1, 32'hFFFFFFA5);
    send("R6 sbyte a3", D, 2'd3, 2'b00, 1'b1, 32'hFFFFFFC3);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rdy = 1'b0;
    in_data = 32'h1122_3344; in_addr = 2'd0; in_size = 2'b10; in_signed = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_data = 32'h5566_7788;
    #1;
    check("R8 first result shown", o_data, 32'h11223344);
    check("R8 in_ready low when stalled", {31'd0, i_ready}, 32'd0);
    check("R9 comb in_ready equals out_ready", {31'd0, c_ready}, 32'd1);
    @(negedge clk);
    check("R8 data held", o_data, 32'h11223344);
    check("R8 valid held", {31'd0, o_valid}, 32'd1);
    rdy = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 queued result after release", o_data, 32'h55667788);
    @(negedge clk);
    check("R7 valid drops when drained", {31'd0, o_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_word();
    t_half_unsigned();
    t_half_signed();
    t_byte();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule